// File: doc/BRIEF.md
# Analog status flag register

This block gathers the status of the analog side of a mixed-signal device into one 16-bit word that software reads over the peripheral bus. Three bits follow live levels: the comparator outputs of two supply rails and an oscillator-ready signal. Five bits are sticky flags. Four of them latch single-cycle event pulses from the surrounding logic: oscillator failure, a brownout on either rail, and ADC data ready. The fifth, ADC overrun, latches when a finished conversion overwrites a result that software has not yet collected.

A status read strobe clears the failure, brownout and overrun flags on the next clock edge. The word returned by that read still shows them set. The data-ready flag is cleared only by a read of the ADC data register. When a set event and a clearing strobe arrive in the same cycle, the set wins. Two interrupt outputs are formed from the overrun and data-ready flags, each gated by an enable input. A general reset clears only the overrun flag and the busy-edge tracker. A power-on reset clears everything.

Top module: `ana_status_reg`

## Requirements
- R1: Bit 15 of the read word follows the rail A comparator level, bit 14 follows the rail B level and bit 11 follows the oscillator-ready level, combinationally and in every cycle.
- R2: Bits 13, 12, 10 to 7, 3 and 0, and every bit above 15 when the bus is wider than 16, always read as 0.
- R3: Bit 1 (data ready) is 1 from the clock edge after a conversion-done pulse until the edge after a data-register read strobe. A status read strobe leaves it unchanged.
- R4: Bit 2 (overrun) becomes 1 on the clock edge where ADC busy is sampled low after being sampled high one edge earlier, provided that data ready was 1 before that edge.
- R5: A status read strobe clears bits 6, 5, 4 and 2 at the next clock edge, unless a set event for that bit arrives in the same cycle. The word presented during the strobe cycle still shows the flags as set.
- R6: When a flag's set event and its clearing strobe occur in the same cycle, the flag is 1 after the edge.
- R7: An active-low general reset clears bit 2 at once and leaves bits 6, 5, 4 and 1 unchanged.
- R8: An active-low power-on reset clears all flag bits (6, 5, 4, 2 and 1) at once.
- R9: The overrun interrupt equals bit 2 AND the overrun enable. The data-ready interrupt equals bit 1 AND the data-ready enable.
- R10: Pulses on the oscillator-fail, rail A brownout and rail B brownout inputs set bits 6, 5 and 4 at the next edge. Each bit then holds until a status read or a power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | General reset, active low, asynchronous |
| rail_a_lvl_i | input | 1 | Live rail A comparator level |
| rail_b_lvl_i | input | 1 | Live rail B comparator level |
| osc_rdy_i | input | 1 | Live oscillator-ready level |
| osc_fail_ev_i | input | 1 | Oscillator failure event pulse |
| rail_a_bo_ev_i | input | 1 | Rail A brownout event pulse |
| rail_b_bo_ev_i | input | 1 | Rail B brownout event pulse |
| conv_done_i | input | 1 | ADC conversion complete pulse |
| adc_busy_i | input | 1 | ADC busy level |
| data_rd_i | input | 1 | ADC data register read strobe |
| stat_rd_i | input | 1 | Status register read strobe |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| rdy_ie_i | input | 1 | Data-ready interrupt enable |
| rdata_o | output | BUS_W | Status word |
| irq_ovr_o | output | 1 | Overrun interrupt |
| irq_rdy_o | output | 1 | Data-ready interrupt |

## Verification
The bench builds the block with BUS_W left at its default of 16. At that width every bit of the word carries a defined meaning, so the reserved-zero mask, the live levels and all five flags can be compared bit for bit against a model kept in the bench. Random streams of events, strobes and busy toggles reach the overlaps that matter: a set and a clear in the same cycle, and a busy fall while data ready is set or clear. Directed steps add both reset domains asserted in the middle of a run.

// File: rtl/ana_status_pkg.sv
package ana_status_pkg;
    localparam int WORD_W      = 16;
    localparam int BIT_RAIL_A  = 15;
    localparam int BIT_RAIL_B  = 14;
    localparam int BIT_OSC_RDY = 11;
    localparam int BIT_OSC_FL  = 6;
    localparam int BIT_BO_A    = 5;
    localparam int BIT_BO_B    = 4;
    localparam int BIT_OVR     = 2;
    localparam int BIT_RDY     = 1;
    localparam int NUM_EV      = 3;   // flags set by external event pulses

    typedef struct packed {
        logic osc_fail;
        logic bo_a;
        logic bo_b;
        logic ovr;
        logic rdy;
    } flags_t;

    typedef struct packed {
        logic rail_a;
        logic rail_b;
        logic osc_rdy;
    } levels_t;
endpackage

// File: rtl/ana_sticky_bit.sv
module ana_sticky_bit (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr_i) q_d = 1'b0;
        if (set_i) q_d = 1'b1;   // set has priority over clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= 1'b0;
        else         q_q <= q_d;
    end

    assign q_o = q_q;

    assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> q_o);
    assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i) |=> !q_o);
    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/ana_busy_fall.sv
module ana_busy_fall (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic busy_i,
    output logic fall_o
);
    typedef struct packed {
        logic busy;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = busy_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fall_o = st_q.busy && !busy_i;

    assert_fall_needs_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> !busy_i);
endmodule

// File: rtl/ana_word_pack.sv
module ana_word_pack
    import ana_status_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  flags_t           flags_i,
    input  levels_t          lvl_i,
    output logic [BUS_W-1:0] word_o
);
    always_comb begin
        word_o              = '0;
        word_o[BIT_RAIL_A]  = lvl_i.rail_a;
        word_o[BIT_RAIL_B]  = lvl_i.rail_b;
        word_o[BIT_OSC_RDY] = lvl_i.osc_rdy;
        word_o[BIT_OSC_FL]  = flags_i.osc_fail;
        word_o[BIT_BO_A]    = flags_i.bo_a;
        word_o[BIT_BO_B]    = flags_i.bo_b;
        word_o[BIT_OVR]     = flags_i.ovr;
        word_o[BIT_RDY]     = flags_i.rdy;
    end
endmodule

// File: rtl/ana_status_reg.sv
module ana_status_reg
    import ana_status_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk_i,
    input  logic             por_ni,
    input  logic             rst_ni,
    input  logic             rail_a_lvl_i,
    input  logic             rail_b_lvl_i,
    input  logic             osc_rdy_i,
    input  logic             osc_fail_ev_i,
    input  logic             rail_a_bo_ev_i,
    input  logic             rail_b_bo_ev_i,
    input  logic             conv_done_i,
    input  logic             adc_busy_i,
    input  logic             data_rd_i,
    input  logic             stat_rd_i,
    input  logic             ovr_ie_i,
    input  logic             rdy_ie_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             irq_ovr_o,
    output logic             irq_rdy_o
);
    localparam int PAD_W = BUS_W - WORD_W;

    flags_t  flags;
    levels_t lvl;
    logic    any_rst_n;
    logic    busy_fall;
    logic [NUM_EV-1:0] ev_set, ev_q;

    // overrun and busy tracker answer to either reset source
    assign any_rst_n = por_ni & rst_ni;
    assign ev_set    = {osc_fail_ev_i, rail_a_bo_ev_i, rail_b_bo_ev_i};

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        ana_sticky_bit u_ev (
            .clk_i (clk_i),
            .rst_ni(por_ni),
            .set_i (ev_set[g]),
            .clr_i (stat_rd_i),
            .q_o   (ev_q[g])
        );
    end

    ana_sticky_bit u_rdy (
        .clk_i (clk_i),
        .rst_ni(por_ni),
        .set_i (conv_done_i),
        .clr_i (data_rd_i),
        .q_o   (flags.rdy)
    );

    ana_busy_fall u_fall (
        .clk_i (clk_i),
        .rst_ni(any_rst_n),
        .busy_i(adc_busy_i),
        .fall_o(busy_fall)
    );

    ana_sticky_bit u_ovr (
        .clk_i (clk_i),
        .rst_ni(any_rst_n),
        .set_i (busy_fall && flags.rdy),
        .clr_i (stat_rd_i),
        .q_o   (flags.ovr)
    );

    assign flags.osc_fail = ev_q[2];
    assign flags.bo_a     = ev_q[1];
    assign flags.bo_b     = ev_q[0];
    assign lvl            = '{rail_a: rail_a_lvl_i, rail_b: rail_b_lvl_i, osc_rdy: osc_rdy_i};

    ana_word_pack #(.BUS_W(BUS_W)) u_pack (
        .flags_i(flags),
        .lvl_i  (lvl),
        .word_o (rdata_o)
    );

    assign irq_ovr_o = flags.ovr & ovr_ie_i;
    assign irq_rdy_o = flags.rdy & rdy_ie_i;

    if (PAD_W < 0) begin : g_bad_width
        initial $error("BUS_W must be at least 16");
    end

    assert_ovr_set_R4: assert property (@(posedge clk_i) disable iff (!any_rst_n)
        (busy_fall && rdata_o[BIT_RDY]) |=> rdata_o[BIT_OVR]);
    assert_rdy_hold_R3: assert property (@(posedge clk_i) disable iff (!por_ni)
        (stat_rd_i && !conv_done_i && !data_rd_i) |=> (rdata_o[BIT_RDY] == $past(rdata_o[BIT_RDY])));
    assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!por_ni)
        (irq_ovr_o |-> ovr_ie_i) and (irq_rdy_o |-> rdy_ie_i));
    assert_ovr_general_reset_R7: assert property (@(posedge clk_i) disable iff (!por_ni)
        !rst_ni |-> !rdata_o[BIT_OVR]);
endmodule

// File: tb/ana_status_reg_bench.sv
module ana_status_reg_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic por_n, rst_n, lvl_a, lvl_b, osc_rdy;
    logic ev_osc, ev_ba, ev_bb, conv, busy, data_rd, stat_rd, ovr_ie, rdy_ie;
    logic [W-1:0] rdata;
    logic irq_ovr, irq_rdy;

    int checks = 0;
    int errors = 0;
    logic m_osc, m_ba, m_bb, m_ovr, m_rdy, m_bprev;

    ana_status_reg #(.BUS_W(W)) u_ana_status_reg (
        .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
        .rail_a_lvl_i(lvl_a), .rail_b_lvl_i(lvl_b), .osc_rdy_i(osc_rdy),
        .osc_fail_ev_i(ev_osc), .rail_a_bo_ev_i(ev_ba), .rail_b_bo_ev_i(ev_bb),
        .conv_done_i(conv), .adc_busy_i(busy), .data_rd_i(data_rd), .stat_rd_i(stat_rd),
        .ovr_ie_i(ovr_ie), .rdy_ie_i(rdy_ie),
        .rdata_o(rdata), .irq_ovr_o(irq_ovr), .irq_rdy_o(irq_rdy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] rsv_mask();
        return 16'b0011_0111_1000_1001;
    endfunction

    task automatic check_all();
        chk("R1 live levels", {29'd0, rdata[15], rdata[14], rdata[11]}, {29'd0, lvl_a, lvl_b, osc_rdy});
        chk("R2 reserved zero", 32'(rdata & rsv_mask()), 32'd0);
        chk("R10 event flags", {29'd0, rdata[6:4]}, {29'd0, m_osc, m_ba, m_bb});
        chk("R4 overrun", {31'd0, rdata[2]}, {31'd0, m_ovr});
        chk("R3 data ready", {31'd0, rdata[1]}, {31'd0, m_rdy});
        chk("R9 interrupts", {30'd0, irq_ovr, irq_rdy}, {30'd0, m_ovr & ovr_ie, m_rdy & rdy_ie});
    endtask

    task automatic clr_pulses();
        ev_osc = 0; ev_ba = 0; ev_bb = 0; conv = 0; data_rd = 0; stat_rd = 0;
    endtask

    // inputs are set at a falling edge; one rising edge; check at the next falling edge
    task automatic tick();
        logic n_osc, n_ba, n_bb, n_ovr, n_rdy;
        n_osc = ev_osc ? 1'b1 : (stat_rd ? 1'b0 : m_osc);
        n_ba  = ev_ba  ? 1'b1 : (stat_rd ? 1'b0 : m_ba);
        n_bb  = ev_bb  ? 1'b1 : (stat_rd ? 1'b0 : m_bb);
        n_rdy = conv   ? 1'b1 : (data_rd ? 1'b0 : m_rdy);
        n_ovr = (m_bprev && !busy && m_rdy) ? 1'b1 : (stat_rd ? 1'b0 : m_ovr);
        @(posedge clk);
        m_osc = n_osc; m_ba = n_ba; m_bb = n_bb; m_rdy = n_rdy; m_ovr = n_ovr; m_bprev = busy;
        @(negedge clk);
        clr_pulses();
        #1;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        por_n = 0; rst_n = 0; lvl_a = 0; lvl_b = 0; osc_rdy = 0; busy = 0;
        ovr_ie = 1; rdy_ie = 1;
        clr_pulses();
        {m_osc, m_ba, m_bb, m_ovr, m_rdy, m_bprev} = '0;
        repeat (2) @(negedge clk);
        #1;
        check_all();   // R8 reset state
        chk("R8 reset word", 32'(rdata), 32'd0);
        por_n = 1; rst_n = 1;
        @(negedge clk);

        // R10 events and R3 conversion done, with live levels set
        lvl_a = 1; osc_rdy = 1;
        ev_osc = 1; ev_ba = 1; ev_bb = 1; conv = 1;
        tick();
        // R5 the strobe cycle still returns the set flags
        stat_rd = 1;
        #1;
        chk("R5 pre-clear value", {29'd0, rdata[6:4]}, 32'd7);
        tick();   // flags 6..4 clear, R3 data ready kept
        chk("R3 kept on status read", {31'd0, rdata[1]}, 32'd1);
        chk("R5 cleared", {29'd0, rdata[6:4]}, 32'd0);

        // R4 overrun: busy high, then fall while data ready
        busy = 1; tick();
        busy = 0; tick();
        chk("R4 overrun set", {31'd0, rdata[2]}, 32'd1);
        ovr_ie = 0; #1;
        chk("R9 overrun gated off", {31'd0, irq_ovr}, 32'd0);
        ovr_ie = 1;

        // R7 general reset clears only overrun
        ev_osc = 1; ev_bb = 1; tick();
        rst_n = 0; #1;
        m_ovr = 0; m_bprev = 0;
        check_all();
        chk("R7 other flags kept", {28'd0, rdata[6], rdata[4], rdata[1], rdata[2]}, 32'b1110);
        @(negedge clk);
        rst_n = 1;

        // R6 set and clear in the same cycle
        ev_ba = 1; stat_rd = 1; tick();
        chk("R6 set wins status read", {31'd0, rdata[5]}, 32'd1);
        conv = 1; data_rd = 1; tick();
        chk("R6 set wins data read", {31'd0, rdata[1]}, 32'd1);
        data_rd = 1; tick();
        chk("R3 cleared by data read", {31'd0, rdata[1]}, 32'd0);
        // busy fall with data ready clear: no overrun (R4)
        stat_rd = 1; busy = 1; tick();
        busy = 0; tick();
        chk("R4 no overrun without ready", {31'd0, rdata[2]}, 32'd0);

        // random phase
        for (int i = 0; i < 600; i++) begin
            lvl_a   = 1'($urandom);
            lvl_b   = 1'($urandom);
            osc_rdy = 1'($urandom);
            ovr_ie  = 1'($urandom);
            rdy_ie  = 1'($urandom);
            ev_osc  = ($urandom % 8) == 0;
            ev_ba   = ($urandom % 8) == 0;
            ev_bb   = ($urandom % 8) == 0;
            conv    = ($urandom % 4) == 0;
            data_rd = ($urandom % 5) == 0;
            stat_rd = ($urandom % 6) == 0;
            if (($urandom % 3) == 0) busy = ~busy;
            #1;
            check_all();
            tick();
        end

        // R8 power-on reset mid-run
        ev_osc = 1; ev_ba = 1; conv = 1; tick();
        por_n = 0; #1;
        {m_osc, m_ba, m_bb, m_ovr, m_rdy, m_bprev} = '0;
        check_all();
        chk("R8 flags cleared", {27'd0, rdata[6:4], rdata[2:1]}, 32'd0);
        @(negedge clk);
        por_n = 1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule